// File: doc/BRIEF.md
# LIN Master Header Generator

This block drives the header of a LIN frame onto a single-wire serial transmit line from the master side. A one-cycle request starts a header. The block then holds the line low for a programmable break, releases it high for a programmable delimiter, and can follow with the sync character and then the protected identifier character. A two-bit select input decides how much of that sequence goes out. Bit timing comes from an external divider as a one-cycle `bit_tick` strobe, so the line changes only on the clock edge where that strobe is high.

The configuration inputs are sampled on the edge that accepts the request, and they are held inside the block until the header ends. Software, or a controlling engine, can therefore set up the next header while the current one is still on the wire. When the last bit of the selected header has run its full bit time, the block raises `done` for one cycle and drops `busy` in the same cycle.

Top module: `lin_hdr_gen`

## Requirements
- R1: While reset is held, and whenever the block is idle, `txd` is 1, `busy` is 0 and `done` is 0.
- R2: If `start` is 1 while `busy` is 0, the request is accepted. `busy` reads 1 in the next cycle, and `txd` stays high until the first `bit_tick` after acceptance. This also holds when `start` is raised in the cycle where `done` is high.
- R3: The break drives `txd` low for (`brk_len_m1` + 1) bit times. The field values 9 to 14 give breaks of 10 to 15 bits. A value below 9 is treated as 9, and a value above 14 is treated as 14.
- R4: The delimiter drives `txd` high for (`dlm_len_m1` + 1) bit times, which gives 1 to 4 bits.
- R5: `hdr_sel` = 0 sends the break and the delimiter only. `hdr_sel` = 1 adds the sync character. `hdr_sel` = 2 or 3 adds the sync character and then the identifier character.
- R6: Each character is sent as one low start bit, then 8 data bits with bit 0 first, then one high stop bit. The sync character carries 0x55.
- R7: The identifier character carries `pid` exactly as given. No parity bits are computed by the block.
- R8: `done` is high for exactly one cycle. That cycle is the one after the `bit_tick` edge that ends the last stop bit, or the last delimiter bit when `hdr_sel` = 0. `busy` is 0 in that same cycle.
- R9: `start` is ignored while `busy` is 1. This includes the cycle of the final `bit_tick`.
- R10: The configuration inputs are captured when a request is accepted. Later changes to them have no effect on the header in progress.
- R11: `txd` changes only on an edge where `bit_tick` is 1. Without ticks, a busy header makes no progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bit_tick | input | 1 | One-cycle strobe per bit time from the external divider |
| start | input | 1 | Header request |
| brk_len_m1 | input | 4 | Break length minus one (9..14) |
| dlm_len_m1 | input | 2 | Delimiter length minus one |
| hdr_sel | input | 2 | Header content select |
| pid | input | 8 | Identifier character value |
| txd | output | 1 | Serial transmit line (registered) |
| busy | output | 1 | Header in progress |
| done | output | 1 | One-cycle end-of-header pulse |

## Verification
Two events can land on the same edge: the final `bit_tick` of a header and a new `start` request. The bench raises `start` together with that last tick. It expects `busy` to be low in the `done` cycle and to stay low in the cycle after, which shows the request was dropped. A second case raises `start` during the `done` cycle itself and expects `busy` high one cycle later, followed by a complete and correct header. A further `start`, combined with configuration changes partway through a header, must leave the serial bit stream exactly as computed from the captured settings.

// File: rtl/lin_hdr_pkg.sv
package lin_hdr_pkg;
  localparam int BRK_FW = 4;
  localparam int DLM_FW = 2;
  localparam int SEL_FW = 2;
  localparam int BYTE_W = 8;

  localparam logic [BRK_FW-1:0] BRK_MIN_M1 = BRK_FW'(9);
  localparam logic [BRK_FW-1:0] BRK_MAX_M1 = BRK_FW'(14);
  localparam logic [BYTE_W-1:0] SYNC_PATTERN = BYTE_W'(8'h55);

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ARM,
    ST_BRK,
    ST_DLM,
    ST_BYTE
  } seq_st_t;

  typedef struct packed {
    logic [BRK_FW-1:0] brk_m1;
    logic [DLM_FW-1:0] dlm_m1;
    logic              send_sync;
    logic              send_pid;
    logic [BYTE_W-1:0] pid;
  } hdr_cfg_t;
endpackage

// File: rtl/lin_hdr_cfg.sv
module lin_hdr_cfg
  import lin_hdr_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              capture,
  input  logic [BRK_FW-1:0] brk_in,
  input  logic [DLM_FW-1:0] dlm_in,
  input  logic [SEL_FW-1:0] sel_in,
  input  logic [BYTE_W-1:0] pid_in,
  output hdr_cfg_t          cfg
);
  hdr_cfg_t nxt;

  // clamp the break field into the legal window and decode the select
  always_comb begin
    nxt = '0;
    if (brk_in < BRK_MIN_M1)      nxt.brk_m1 = BRK_MIN_M1;
    else if (brk_in > BRK_MAX_M1) nxt.brk_m1 = BRK_MAX_M1;
    else                          nxt.brk_m1 = brk_in;
    nxt.dlm_m1    = dlm_in;
    nxt.send_sync = (sel_in != '0);
    nxt.send_pid  = sel_in[SEL_FW-1];
    nxt.pid       = pid_in;
  end

  always_ff @(posedge clk) begin
    if (rst)          cfg <= '0;
    else if (capture) cfg <= nxt;
  end
endmodule

// File: rtl/lin_hdr_ser.sv
module lin_hdr_ser #(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic              shift,
  input  logic [BYTE_W-1:0] data,
  output logic              bit_o,
  output logic              empty
);
  localparam int CNT_W = $clog2(BYTE_W + 2);
  localparam logic [CNT_W-1:0] TAIL = CNT_W'(BYTE_W + 1);

  logic [BYTE_W:0]  sh;
  logic [CNT_W-1:0] left;

  // start bit is presented by the sequencer on load; data and stop remain
  always_ff @(posedge clk) begin
    if (rst) begin
      sh   <= '1;
      left <= '0;
    end else if (load) begin
      sh   <= {1'b1, data};
      left <= TAIL;
    end else if (shift) begin
      sh   <= {1'b1, sh[BYTE_W:1]};
      left <= left - 1'b1;
    end
  end

  assign bit_o = sh[0];
  assign empty = (left == '0);
endmodule

// File: rtl/lin_hdr_seq.sv
module lin_hdr_seq
  import lin_hdr_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              bit_tick,
  input  logic              start,
  input  hdr_cfg_t          cfg,
  input  logic              ser_bit,
  input  logic              ser_empty,
  output logic              capture,
  output logic              ser_load,
  output logic              ser_shift,
  output logic [BYTE_W-1:0] ser_data,
  output logic              txd,
  output logic              busy,
  output logic              done
);
  seq_st_t           st;
  logic [BRK_FW-1:0] cnt;
  logic              on_pid;
  logic              dlm_end, byte_end, finish;

  always_comb begin
    capture   = start && (st == ST_IDLE);
    dlm_end   = bit_tick && (st == ST_DLM) && (cnt == '0);
    byte_end  = bit_tick && (st == ST_BYTE) && ser_empty;
    ser_load  = (dlm_end && cfg.send_sync) ||
                (byte_end && !on_pid && cfg.send_pid);
    ser_shift = bit_tick && (st == ST_BYTE) && !ser_empty;
    ser_data  = (st == ST_DLM) ? SYNC_PATTERN : cfg.pid;
    finish    = (dlm_end && !cfg.send_sync) || (byte_end && !ser_load);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st     <= ST_IDLE;
      cnt    <= '0;
      on_pid <= 1'b0;
      txd    <= 1'b1;
      busy   <= 1'b0;
      done   <= 1'b0;
    end else begin
      done <= finish;
      unique case (st)
        ST_IDLE: if (start) begin
          st     <= ST_ARM;
          busy   <= 1'b1;
          on_pid <= 1'b0;
        end
        ST_ARM: if (bit_tick) begin
          txd <= 1'b0;
          cnt <= cfg.brk_m1;
          st  <= ST_BRK;
        end
        ST_BRK: if (bit_tick) begin
          if (cnt == '0) begin
            txd <= 1'b1;
            cnt <= BRK_FW'(cfg.dlm_m1);
            st  <= ST_DLM;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        ST_DLM: if (bit_tick) begin
          if (cnt != '0) begin
            cnt <= cnt - 1'b1;
          end else if (cfg.send_sync) begin
            txd <= 1'b0;
            st  <= ST_BYTE;
          end else begin
            st   <= ST_IDLE;
            busy <= 1'b0;
          end
        end
        ST_BYTE: if (bit_tick) begin
          if (!ser_empty) begin
            txd <= ser_bit;
          end else if (ser_load) begin
            txd    <= 1'b0;
            on_pid <= 1'b1;
          end else begin
            st   <= ST_IDLE;
            busy <= 1'b0;
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/lin_hdr_gen.sv
module lin_hdr_gen
  import lin_hdr_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              bit_tick,
  input  logic              start,
  input  logic [BRK_FW-1:0] brk_len_m1,
  input  logic [DLM_FW-1:0] dlm_len_m1,
  input  logic [SEL_FW-1:0] hdr_sel,
  input  logic [BYTE_W-1:0] pid,
  output logic              txd,
  output logic              busy,
  output logic              done
);
  hdr_cfg_t          cfg;
  logic              capture, ser_load, ser_shift, ser_bit, ser_empty;
  logic [BYTE_W-1:0] ser_data;

  lin_hdr_cfg u_cfg (
    .clk(clk), .rst(rst), .capture(capture),
    .brk_in(brk_len_m1), .dlm_in(dlm_len_m1), .sel_in(hdr_sel), .pid_in(pid),
    .cfg(cfg)
  );

  lin_hdr_ser #(.BYTE_W(BYTE_W)) u_ser (
    .clk(clk), .rst(rst), .load(ser_load), .shift(ser_shift),
    .data(ser_data), .bit_o(ser_bit), .empty(ser_empty)
  );

  lin_hdr_seq u_seq (
    .clk(clk), .rst(rst), .bit_tick(bit_tick), .start(start), .cfg(cfg),
    .ser_bit(ser_bit), .ser_empty(ser_empty), .capture(capture),
    .ser_load(ser_load), .ser_shift(ser_shift), .ser_data(ser_data),
    .txd(txd), .busy(busy), .done(done)
  );
endmodule

// File: rtl/lin_hdr_chk.sv
module lin_hdr_chk (
  input logic clk,
  input logic rst,
  input logic bit_tick,
  input logic start,
  input logic txd,
  input logic busy,
  input logic done
);
  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst) done |=> !done);
  // R8
  done_idle_chk: assert property (@(posedge clk) disable iff (rst) done |-> !busy);
  // R8
  done_tick_chk: assert property (@(posedge clk) disable iff (rst) done |-> $past(bit_tick));
  // R2
  start_accept_chk: assert property (@(posedge clk) disable iff (rst) (start && !busy) |=> busy);
  // R11
  line_gate_chk: assert property (@(posedge clk) disable iff (rst) !bit_tick |=> $stable(txd));
  // R11
  busy_hold_chk: assert property (@(posedge clk) disable iff (rst) (busy && !bit_tick) |=> busy);
  // R1
  idle_high_chk: assert property (@(posedge clk) disable iff (rst) !busy |-> txd);
endmodule

bind lin_hdr_gen lin_hdr_chk u_chk (
  .clk(clk), .rst(rst), .bit_tick(bit_tick), .start(start),
  .txd(txd), .busy(busy), .done(done)
);

// File: tb/lin_hdr_gen_test.sv
module lin_hdr_gen_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       bit_tick = 1'b0;
  logic       start = 1'b0;
  logic [3:0] brk_len_m1 = 4'd11;
  logic [1:0] dlm_len_m1 = 2'd0;
  logic [1:0] hdr_sel = 2'd0;
  logic [7:0] pid = 8'h00;
  logic       txd, busy, done;

  int checks = 0;
  int errors = 0;
  logic exp_bits [64];
  int   exp_n;
  int   mism;
  logic [1:0] vs, vd;
  logic [3:0] vb;
  logic [7:0] vp;

  // {hdr_sel, brk_len_m1, dlm_len_m1, pid}
  localparam logic [15:0] VEC [7] = '{
    {2'd0, 4'd11, 2'd0, 8'h00},
    {2'd1, 4'd9,  2'd3, 8'h00},
    {2'd2, 4'd14, 2'd1, 8'hA3},
    {2'd2, 4'd10, 2'd2, 8'h00},
    {2'd3, 4'd12, 2'd0, 8'h5E},
    {2'd1, 4'd2,  2'd0, 8'h00},
    {2'd0, 4'd15, 2'd1, 8'h00}
  };

  always #4 clk = ~clk;

  lin_hdr_gen uut (
    .clk(clk), .rst(rst), .bit_tick(bit_tick), .start(start),
    .brk_len_m1(brk_len_m1), .dlm_len_m1(dlm_len_m1), .hdr_sel(hdr_sel),
    .pid(pid), .txd(txd), .busy(busy), .done(done)
  );

  task automatic check(input string req, input logic ok, input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  task automatic push(input logic b);
    exp_bits[exp_n] = b;
    exp_n++;
  endtask

  task automatic push_char(input logic [7:0] c);
    push(1'b0);
    for (int i = 0; i < 8; i++) push(c[i]);
    push(1'b1);
  endtask

  task automatic build_exp(input logic [1:0] s, input logic [3:0] b,
                           input logic [1:0] d, input logic [7:0] p);
    int nb;
    nb = (b < 4'd9) ? 10 : (b > 4'd14) ? 15 : int'(b) + 1;
    exp_n = 0;
    for (int i = 0; i < nb; i++) push(1'b0);
    for (int i = 0; i <= int'(d); i++) push(1'b1);
    if (s != 2'd0) push_char(8'h55);
    if (s[1]) push_char(p);
  endtask

  task automatic pulse_tick(input logic with_start);
    repeat (2) @(negedge clk);
    bit_tick = 1'b1;
    start = with_start;
    @(negedge clk);
    bit_tick = 1'b0;
    start = 1'b0;
  endtask

  task automatic begin_frame();
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    check("R2 accept", busy === 1'b1 && txd === 1'b1, {busy, txd}, 2'b11);
  endtask

  task automatic play(input logic mid_start, output int m);
    m = 0;
    for (int k = 0; k < exp_n; k++) begin
      pulse_tick(mid_start && k == 5);
      if (txd !== exp_bits[k] || done !== 1'b0) m++;
    end
  endtask

  task automatic end_frame(input logic final_start);
    pulse_tick(final_start);
    check("R8 done", done === 1'b1 && busy === 1'b0 && txd === 1'b1,
          {done, busy, txd}, 3'b101);
    @(negedge clk);
    check("R8 single", done === 1'b0 && busy === 1'b0, {done, busy}, 2'b00);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 reset", txd === 1'b1 && busy === 1'b0 && done === 1'b0,
          {txd, busy, done}, 3'b100);
    rst = 1'b0;
    @(negedge clk);

    // table walk: R3 R4 R5 R6 R7 R8
    for (int v = 0; v < 7; v++) begin
      {vs, vb, vd, vp} = VEC[v];
      hdr_sel = vs; brk_len_m1 = vb; dlm_len_m1 = vd; pid = vp;
      build_exp(vs, vb, vd, vp);
      begin_frame();
      play(1'b0, mism);
      check("R3 R4 R5 R6 R7 bit stream", mism == 0, mism, 0);
      end_frame(1'b0);
    end

    // R9 R10 R11: stall, mid-frame start and config change, start on last tick
    hdr_sel = 2'd2; brk_len_m1 = 4'd11; dlm_len_m1 = 2'd1; pid = 8'h3C;
    build_exp(2'd2, 4'd11, 2'd1, 8'h3C);
    begin_frame();
    repeat (6) @(negedge clk);
    check("R11 no tick", txd === 1'b1 && busy === 1'b1, {txd, busy}, 2'b11);
    hdr_sel = 2'd0; brk_len_m1 = 4'd9; pid = 8'hFF;
    play(1'b1, mism);
    check("R9 R10 bit stream", mism == 0, mism, 0);
    end_frame(1'b1);
    check("R9 final start ignored", busy === 1'b0 && txd === 1'b1, {busy, txd}, 2'b01);

    // R2: request in the done cycle is accepted
    hdr_sel = 2'd1; brk_len_m1 = 4'd9; dlm_len_m1 = 2'd0; pid = 8'h00;
    build_exp(2'd1, 4'd9, 2'd0, 8'h00);
    begin_frame();
    play(1'b0, mism);
    check("R6 bit stream", mism == 0, mism, 0);
    pulse_tick(1'b0);
    check("R8 done", done === 1'b1 && busy === 1'b0, {done, busy}, 2'b10);
    start = 1'b1;
    @(negedge clk) start = 1'b0;
    check("R2 done-cycle start", busy === 1'b1, busy, 1);
    play(1'b0, mism);
    check("R2 back-to-back stream", mism == 0, mism, 0);
    end_frame(1'b0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule